// File: doc/BRIEF.md
# Interrupt presentation controller

This block sits beside one processor and decides which single interrupt that processor is being offered at any moment. Source controllers send presentation requests, each with a source number and a priority. The block keeps one pending slot. A more favoured request can take that slot from the interrupt already in it, and an interrupt pushed out this way is handed back to its own source. A local inter-processor interrupt (IPI) priority register competes for the same slot, using a fixed source number. A numerically lower priority is more favoured.

The processor uses five operations. It can write its current priority, write the IPI priority, accept the pending interrupt (a read with side effects), poll (a read without side effects), and signal end of interrupt. Towards the sources the block sends three kinds of one-cycle strobe: reject (for a request that lost or an interrupt that was displaced), EOI, and a broadcast resend.

Every output is registered, so it appears one clock after the cycle that caused it. When a register operation and a presentation request arrive in the same cycle, the operation is applied first and the request is judged against the state the operation leaves behind.

Top module: `irq_presenter`

## Requirements
- R1: After synchronous reset, the status word is 0x00000000, the pending priority and the IPI priority are both 0xFF, `irq_out` is low and no strobe is active.
- R2: A request is rejected back on `rej_req_src` when either of these holds: its priority is not strictly below the current priority, or an interrupt is pending whose priority is at or below the request's priority.
- R3: A winning request replaces the pending interrupt and raises `irq_out`. The new source number and priority are latched. A displaced external interrupt is rejected to its source. A displaced IPI is never rejected. Source numbers 0 (empty) and 2 (IPI) are reserved.
- R4: Accept (`op_code` 3) returns the status word as it stood before the operation: current priority in bits 31:24 and pending source in bits 23:0. It then lowers `irq_out`, copies the pending priority into the current priority, clears the source field and sets the pending priority to 0xFF.
- R5: A current-priority write (`op_code` 1, value in `op_wdata[7:0]`) that is more favoured than the old value clears the pending interrupt when the new value is at or below the pending priority. Clearing sets the pending priority to 0xFF, lowers `irq_out`, and rejects the interrupt to its source if it is external.
- R6: A current-priority write that is not more favoured than the old value, made while nothing is pending, pulses `resend` and then performs the IPI check.
- R7: An IPI priority write (`op_code` 2, value in `op_wdata[7:0]`) performs the IPI check. The check acts only when the IPI priority is below the current priority. It then takes the slot unless the pending priority is at or below the IPI priority. Taking the slot latches source 2 with the IPI priority and raises `irq_out`.
- R8: End of interrupt (`op_code` 5) loads `op_wdata[31:24]` into the current priority and sends an EOI carrying `op_wdata[23:0]`. If nothing is pending afterwards, it also pulses `resend` and performs the IPI check.
- R9: Poll (`op_code` 4) returns the status word and the IPI priority and changes no state.
- R10: When an operation and a request arrive in the same cycle, the request is judged against the state after the operation.
- R11: `irq_out` is high exactly when the pending source field is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Register operation strobe |
| op_code | input | 3 | 1 current priority, 2 IPI priority, 3 accept, 4 poll, 5 end of interrupt |
| op_wdata | input | 32 | Write value for the operation |
| req_valid | input | 1 | Presentation request strobe |
| req_src | input | 24 | Requesting source number |
| req_pri | input | 8 | Requested priority |
| rd_valid | output | 1 | Read result strobe (accept or poll) |
| rd_word | output | 32 | Status word before the operation |
| rd_ipi_pri | output | 8 | IPI priority register |
| rej_op_valid | output | 1 | Reject caused by a register operation |
| rej_op_src | output | 24 | Source of that reject |
| rej_req_valid | output | 1 | Reject caused by a request |
| rej_req_src | output | 24 | Source of that reject |
| eoi_valid | output | 1 | End-of-interrupt strobe to sources |
| eoi_src | output | 24 | Source being completed |
| resend | output | 1 | Broadcast resend pulse |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The bench targets the equal-priority edges, where a design that uses `<=` in place of `<` would accept a tie instead of rejecting it. It also covers an IPI displaced by an external request, where a careless owner check would send a spurious reject carrying source 2. It covers accept, which must hand back the pre-operation word and move the pending priority into the current priority; a design that got this wrong would leave the processor at the wrong level. Finally it sends an operation and a request in the same cycle, so that a design that applied the request first would reject work it should take.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    localparam int SRC_W  = 24;
    localparam int PRI_W  = 8;
    localparam int WORD_W = SRC_W + PRI_W;

    localparam logic [SRC_W-1:0] IPI_SRC   = SRC_W'(2);
    localparam logic [SRC_W-1:0] NO_SRC    = '0;
    localparam logic [PRI_W-1:0] PRI_LEAST = '1;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_SET_CUR  = 3'd1,
        OP_SET_IPI  = 3'd2,
        OP_ACCEPT   = 3'd3,
        OP_POLL     = 3'd4,
        OP_EOI      = 3'd5
    } op_e;

    typedef struct packed {
        logic [PRI_W-1:0] cur_pri;
        logic [SRC_W-1:0] pend_src;
        logic [PRI_W-1:0] pend_pri;
        logic [PRI_W-1:0] ipi_pri;
        logic             pend_ext;
    } pres_st_t;

    typedef struct packed {
        logic             vld;
        logic [SRC_W-1:0] src;
    } src_evt_t;

    function automatic logic [WORD_W-1:0] status_word(pres_st_t s);
        return {s.cur_pri, s.pend_src};
    endfunction

    function automatic pres_st_t reset_state();
        pres_st_t s;
        s.cur_pri  = '0;
        s.pend_src = NO_SRC;
        s.pend_pri = PRI_LEAST;
        s.ipi_pri  = PRI_LEAST;
        s.pend_ext = 1'b0;
        return s;
    endfunction

    function automatic logic has_pending(pres_st_t s);
        return s.pend_src != NO_SRC;
    endfunction

endpackage

// File: rtl/irqp_ipi_gate.sv
module irqp_ipi_gate
    import irqp_pkg::*;
(
    input  pres_st_t st_in,
    input  logic     chk_en,
    output pres_st_t st_out,
    output src_evt_t rej,
    output logic     raise
);
    logic ipi_beats_cur;
    logic slot_holds;

    always_comb begin
        ipi_beats_cur = st_in.ipi_pri < st_in.cur_pri;
        slot_holds    = has_pending(st_in) && (st_in.pend_pri <= st_in.ipi_pri);
        st_out        = st_in;
        rej           = '0;
        raise         = 1'b0;
        if (chk_en && ipi_beats_cur && !slot_holds) begin
            if (has_pending(st_in) && st_in.pend_ext) begin
                rej.vld = 1'b1;
                rej.src = st_in.pend_src;
            end
            st_out.pend_src = IPI_SRC;
            st_out.pend_pri = st_in.ipi_pri;
            st_out.pend_ext = 1'b0;
            raise           = 1'b1;
        end
    end

endmodule

// File: rtl/irqp_op_unit.sv
module irqp_op_unit
    import irqp_pkg::*;
(
    input  pres_st_t          st_in,
    input  logic              op_valid,
    input  op_e               op_code,
    input  logic [WORD_W-1:0] op_wdata,
    output pres_st_t          st_out,
    output src_evt_t          rej,
    output src_evt_t          eoi,
    output logic              resend,
    output logic              rd_fire,
    output logic [WORD_W-1:0] rd_word,
    output logic              raise,
    output logic              lower
);
    pres_st_t         st_a;
    src_evt_t         rej_a;
    src_evt_t         rej_gate;
    logic             chk_en;
    logic [PRI_W-1:0] new_pri;

    always_comb begin
        st_a    = st_in;
        rej_a   = '0;
        eoi     = '0;
        resend  = 1'b0;
        rd_fire = 1'b0;
        rd_word = status_word(st_in);
        lower   = 1'b0;
        chk_en  = 1'b0;
        new_pri = op_wdata[PRI_W-1:0];
        if (op_valid) begin
            case (op_code)
                OP_SET_CUR: begin
                    st_a.cur_pri = new_pri;
                    if (new_pri < st_in.cur_pri) begin
                        if (has_pending(st_in) && (new_pri <= st_in.pend_pri)) begin
                            if (st_in.pend_ext) begin
                                rej_a.vld = 1'b1;
                                rej_a.src = st_in.pend_src;
                            end
                            st_a.pend_src = NO_SRC;
                            st_a.pend_pri = PRI_LEAST;
                            st_a.pend_ext = 1'b0;
                            lower         = 1'b1;
                        end
                    end else if (!has_pending(st_in)) begin
                        resend = 1'b1;
                        chk_en = 1'b1;
                    end
                end
                OP_SET_IPI: begin
                    st_a.ipi_pri = new_pri;
                    chk_en       = 1'b1;
                end
                OP_ACCEPT: begin
                    rd_fire       = 1'b1;
                    st_a.cur_pri  = st_in.pend_pri;
                    st_a.pend_src = NO_SRC;
                    st_a.pend_pri = PRI_LEAST;
                    st_a.pend_ext = 1'b0;
                    lower         = 1'b1;
                end
                OP_POLL: begin
                    rd_fire = 1'b1;
                end
                OP_EOI: begin
                    st_a.cur_pri = op_wdata[WORD_W-1:SRC_W];
                    eoi.vld      = 1'b1;
                    eoi.src      = op_wdata[SRC_W-1:0];
                    if (!has_pending(st_in)) begin
                        resend = 1'b1;
                        chk_en = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    irqp_ipi_gate u_ipi_gate (
        .st_in  (st_a),
        .chk_en (chk_en),
        .st_out (st_out),
        .rej    (rej_gate),
        .raise  (raise)
    );

    assign rej = rej_a.vld ? rej_a : rej_gate;

endmodule

// File: rtl/irqp_req_arb.sv
module irqp_req_arb
    import irqp_pkg::*;
(
    input  pres_st_t         st_in,
    input  logic             req_valid,
    input  logic [SRC_W-1:0] req_src,
    input  logic [PRI_W-1:0] req_pri,
    output pres_st_t         st_out,
    output src_evt_t         rej,
    output logic             raise
);
    logic loses_to_cur;
    logic loses_to_pend;

    always_comb begin
        loses_to_cur  = req_pri >= st_in.cur_pri;
        loses_to_pend = has_pending(st_in) && (st_in.pend_pri <= req_pri);
        st_out        = st_in;
        rej           = '0;
        raise         = 1'b0;
        if (req_valid) begin
            if (loses_to_cur || loses_to_pend) begin
                rej.vld = 1'b1;
                rej.src = req_src;
            end else begin
                if (has_pending(st_in) && st_in.pend_ext) begin
                    rej.vld = 1'b1;
                    rej.src = st_in.pend_src;
                end
                st_out.pend_src = req_src;
                st_out.pend_pri = req_pri;
                st_out.pend_ext = 1'b1;
                raise           = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irqp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [WORD_W-1:0] op_wdata,
    input  logic              req_valid,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [PRI_W-1:0]  req_pri,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_word,
    output logic [PRI_W-1:0]  rd_ipi_pri,
    output logic              rej_op_valid,
    output logic [SRC_W-1:0]  rej_op_src,
    output logic              rej_req_valid,
    output logic [SRC_W-1:0]  rej_req_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend,
    output logic              irq_out
);
    pres_st_t          st_q;
    pres_st_t          st_mid;
    pres_st_t          st_nxt;
    src_evt_t          op_rej;
    src_evt_t          op_eoi;
    src_evt_t          arb_rej;
    logic              op_resend;
    logic              op_rd;
    logic [WORD_W-1:0] op_rd_word;
    logic              op_raise;
    logic              op_lower;
    logic              arb_raise;
    op_e               op_kind;

    assign op_kind = op_e'(op_code);

    // register operations act first, the request sees their result
    irqp_op_unit u_op_unit (
        .st_in    (st_q),
        .op_valid (op_valid),
        .op_code  (op_kind),
        .op_wdata (op_wdata),
        .st_out   (st_mid),
        .rej      (op_rej),
        .eoi      (op_eoi),
        .resend   (op_resend),
        .rd_fire  (op_rd),
        .rd_word  (op_rd_word),
        .raise    (op_raise),
        .lower    (op_lower)
    );

    irqp_req_arb u_req_arb (
        .st_in     (st_mid),
        .req_valid (req_valid),
        .req_src   (req_src),
        .req_pri   (req_pri),
        .st_out    (st_nxt),
        .rej       (arb_rej),
        .raise     (arb_raise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= reset_state();
            irq_out       <= 1'b0;
            rd_valid      <= 1'b0;
            rd_word       <= '0;
            rd_ipi_pri    <= '0;
            rej_op_valid  <= 1'b0;
            rej_op_src    <= '0;
            rej_req_valid <= 1'b0;
            rej_req_src   <= '0;
            eoi_valid     <= 1'b0;
            eoi_src       <= '0;
            resend        <= 1'b0;
        end else begin
            st_q          <= st_nxt;
            if (op_raise || arb_raise) begin
                irq_out <= 1'b1;
            end else if (op_lower) begin
                irq_out <= 1'b0;
            end
            rd_valid      <= op_rd;
            if (op_rd) begin
                rd_word    <= op_rd_word;
                rd_ipi_pri <= st_q.ipi_pri;
            end
            rej_op_valid  <= op_rej.vld;
            rej_op_src    <= op_rej.src;
            rej_req_valid <= arb_rej.vld;
            rej_req_src   <= arb_rej.src;
            eoi_valid     <= op_eoi.vld;
            eoi_src       <= op_eoi.src;
            resend        <= op_resend;
        end
    end

    AST_IRQ_TRACKS_SLOT: assert property (@(posedge clk) disable iff (rst)
        irq_out == has_pending(st_q)); // R11

    AST_EMPTY_SLOT_LEAST: assert property (@(posedge clk) disable iff (rst)
        !has_pending(st_q) |-> (st_q.pend_pri == PRI_LEAST)); // R4

    AST_POLL_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd4 && !req_valid) |=> $stable(st_q)); // R9

    AST_ACCEPT_DROPS_LINE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd3 && !req_valid) |=> !irq_out); // R4

    AST_IPI_NOT_BOUNCED_OP: assert property (@(posedge clk) disable iff (rst)
        rej_op_valid |-> (rej_op_src != IPI_SRC)); // R3

    AST_IPI_NOT_BOUNCED_REQ: assert property (@(posedge clk) disable iff (rst)
        (rej_req_valid && $past(req_src) != IPI_SRC) |-> (rej_req_src != IPI_SRC)); // R3

endmodule

// File: tb/irq_presenter_test.sv
module irq_presenter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] op_wdata = '0;
    logic        req_valid = 1'b0;
    logic [23:0] req_src = '0;
    logic [7:0]  req_pri = '0;
    logic        rd_valid;
    logic [31:0] rd_word;
    logic [7:0]  rd_ipi_pri;
    logic        rej_op_valid;
    logic [23:0] rej_op_src;
    logic        rej_req_valid;
    logic [23:0] rej_req_src;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        resend;
    logic        irq_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_presenter uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_wdata(op_wdata), .req_valid(req_valid), .req_src(req_src),
        .req_pri(req_pri), .rd_valid(rd_valid), .rd_word(rd_word),
        .rd_ipi_pri(rd_ipi_pri), .rej_op_valid(rej_op_valid),
        .rej_op_src(rej_op_src), .rej_req_valid(rej_req_valid),
        .rej_req_src(rej_req_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .resend(resend), .irq_out(irq_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench view of the presenter
    logic [7:0]  m_cur, m_pp, m_ipi;
    logic [23:0] m_src;
    logic        m_ext, m_irq;
    logic        e_rd, e_rjo, e_rjr, e_eoi, e_res;
    logic [31:0] e_word;
    logic [7:0]  e_ipi;
    logic [23:0] e_rjo_src, e_rjr_src, e_eoi_src;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cur = 8'h00; m_src = '0; m_pp = 8'hFF; m_ipi = 8'hFF;
        m_ext = 1'b0;  m_irq = 1'b0;
    endtask

    task automatic model(input logic ov, input logic [2:0] oc, input logic [31:0] wd,
                         input logic rv, input logic [23:0] rs, input logic [7:0] rp);
        logic chk_ipi;
        logic [7:0] old;
        chk_ipi = 1'b0;
        e_rd = 0; e_rjo = 0; e_rjr = 0; e_eoi = 0; e_res = 0;
        e_word = {m_cur, m_src}; e_ipi = m_ipi;
        e_rjo_src = '0; e_rjr_src = '0; e_eoi_src = '0;
        if (ov) begin
            case (oc)
                3'd1: begin
                    old = m_cur; m_cur = wd[7:0];
                    if (wd[7:0] < old) begin
                        if (m_src != 0 && wd[7:0] <= m_pp) begin
                            if (m_ext) begin e_rjo = 1; e_rjo_src = m_src; end
                            m_src = 0; m_pp = 8'hFF; m_ext = 0; m_irq = 0;
                        end
                    end else if (m_src == 0) begin
                        e_res = 1; chk_ipi = 1;
                    end
                end
                3'd2: begin m_ipi = wd[7:0]; chk_ipi = 1; end
                3'd3: begin
                    e_rd = 1; m_cur = m_pp; m_src = 0; m_pp = 8'hFF; m_ext = 0; m_irq = 0;
                end
                3'd4: e_rd = 1;
                3'd5: begin
                    m_cur = wd[31:24]; e_eoi = 1; e_eoi_src = wd[23:0];
                    if (m_src == 0) begin e_res = 1; chk_ipi = 1; end
                end
                default: ;
            endcase
        end
        if (chk_ipi && m_ipi < m_cur && !(m_src != 0 && m_pp <= m_ipi)) begin
            if (m_src != 0 && m_ext) begin e_rjo = 1; e_rjo_src = m_src; end
            m_src = 24'd2; m_pp = m_ipi; m_ext = 0; m_irq = 1;
        end
        if (rv) begin
            if (rp >= m_cur || (m_src != 0 && m_pp <= rp)) begin
                e_rjr = 1; e_rjr_src = rs;
            end else begin
                if (m_src != 0 && m_ext) begin e_rjr = 1; e_rjr_src = m_src; end
                m_src = rs; m_pp = rp; m_ext = 1; m_irq = 1;
            end
        end
    endtask

    // drive at the falling edge, compare one rising edge later
    task automatic step(input logic ov, input logic [2:0] oc, input logic [31:0] wd,
                        input logic rv, input logic [23:0] rs, input logic [7:0] rp);
        op_valid = ov; op_code = oc; op_wdata = wd;
        req_valid = rv; req_src = rs; req_pri = rp;
        model(ov, oc, wd, rv, rs, rp);
        @(posedge clk);
        @(negedge clk);
        op_valid = 0; req_valid = 0;
        chk("R11 irq_out", {31'd0, irq_out}, {31'd0, m_irq});
        chk("R4/R9 rd_valid", {31'd0, rd_valid}, {31'd0, e_rd});
        if (e_rd) chk("R4/R9 rd_word", rd_word, e_word);
        if (e_rd && oc == 3'd4) chk("R9 rd_ipi_pri", {24'd0, rd_ipi_pri}, {24'd0, e_ipi});
        chk("R5/R7 rej_op_valid", {31'd0, rej_op_valid}, {31'd0, e_rjo});
        if (e_rjo) chk("R5/R7 rej_op_src", {8'd0, rej_op_src}, {8'd0, e_rjo_src});
        chk("R2/R3 rej_req_valid", {31'd0, rej_req_valid}, {31'd0, e_rjr});
        if (e_rjr) chk("R2/R3 rej_req_src", {8'd0, rej_req_src}, {8'd0, e_rjr_src});
        chk("R8 eoi_valid", {31'd0, eoi_valid}, {31'd0, e_eoi});
        if (e_eoi) chk("R8 eoi_src", {8'd0, eoi_src}, {8'd0, e_eoi_src});
        chk("R6 resend", {31'd0, resend}, {31'd0, e_res});
    endtask

    task automatic poll_expect(input string tag, input logic [31:0] word, input logic [7:0] ipi);
        step(1, 3'd4, 0, 0, 0, 0);
        chk(tag, rd_word, word);
        chk(tag, {24'd0, rd_ipi_pri}, {24'd0, ipi});
    endtask

    function automatic logic [7:0] rnd_pri();
        return ($urandom % 8 == 0) ? 8'hFF : 8'($urandom % 8);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset values seen through poll
        chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
        chk("R1 resend after reset", {31'd0, resend}, 32'd0);
        poll_expect("R1 reset word/ipi", 32'h0000_0000, 8'hFF);
        // R6 widen window with empty slot
        step(1, 3'd1, 32'hFF, 0, 0, 0);
        chk("R6 resend on open", {31'd0, resend}, 32'd1);
        step(0, 0, 0, 1, 24'd10, 8'd5);
        chk("R3 first win", {31'd0, irq_out}, 32'd1);
        poll_expect("R3 latched word", 32'hFF00_000A, 8'hFF);
        step(0, 0, 0, 1, 24'd11, 8'd5);
        chk("R2 tie rejected", {8'd0, rej_req_src}, 32'd11);
        step(0, 0, 0, 1, 24'd12, 8'd3);
        chk("R3 displaced bounced", {8'd0, rej_req_src}, 32'd10);
        // R7 IPI takes the slot
        step(1, 3'd2, 32'd1, 0, 0, 0);
        chk("R7 ipi bounces ext", {8'd0, rej_op_src}, 32'd12);
        poll_expect("R7 ipi word", 32'hFF00_0002, 8'h01);
        step(0, 0, 0, 1, 24'd13, 8'd0);
        chk("R3 ipi not bounced", {31'd0, rej_req_valid}, 32'd0);
        // R4 accept
        step(1, 3'd3, 0, 0, 0, 0);
        chk("R4 accept word", rd_word, 32'hFF00_000D);
        chk("R4 accept drops", {31'd0, irq_out}, 32'd0);
        poll_expect("R4 cur takes pend pri", 32'h0000_0000, 8'h01);
        // R8 eoi then ipi check
        step(1, 3'd5, 32'hFF00_000D, 0, 0, 0);
        chk("R8 eoi src", {8'd0, eoi_src}, 32'd13);
        chk("R8 resend", {31'd0, resend}, 32'd1);
        chk("R8 ipi relatched", {31'd0, irq_out}, 32'd1);
        // R5 tightening clears
        step(1, 3'd1, 32'd1, 0, 0, 0);
        chk("R5 ipi cleared quietly", {31'd0, rej_op_valid}, 32'd0);
        step(1, 3'd2, 32'hFF, 0, 0, 0);
        step(1, 3'd1, 32'hFF, 0, 0, 0);
        step(0, 0, 0, 1, 24'd20, 8'd4);
        step(1, 3'd1, 32'd2, 0, 0, 0);
        chk("R5 ext cleared bounced", {8'd0, rej_op_src}, 32'd20);
        chk("R5 line low", {31'd0, irq_out}, 32'd0);
        // R10 op before request in one cycle
        step(1, 3'd1, 32'hFF, 1, 24'd21, 8'd9);
        chk("R10 request sees new cur", {31'd0, rej_req_valid}, 32'd0);
        chk("R10 latched", {31'd0, irq_out}, 32'd1);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic ov, rv;
            logic [2:0] oc;
            logic [31:0] wd;
            ov = ($urandom % 10) < 6;
            oc = 3'(1 + $urandom % 5);
            wd = {rnd_pri(), 24'(3 + $urandom % 60)};
            if (oc != 3'd5) wd = {24'd0, rnd_pri()};
            rv = ($urandom % 2) == 1;
            step(ov, oc, wd, rv, 24'(3 + $urandom % 60), rnd_pri());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule